// File: doc/BRIEF.md
# Conversion Result Stack

This block sits between a successive-approximation converter and a two-wire serial slave. When a valid conversion command arrives, it wakes the converter and keeps it converting back to back, storing every finished 12-bit result on a small last-in first-out stack of four entries. The stack can fill during a slow bus transaction before the read address comes in. Conversion stops, and the converter is put back to sleep, on any of four events: a read address, a bus STOP, a not-acknowledge after a repeated command, or a flush caused by a malformed command.

After conversion stops, the serial side pops one result per two-byte word. The top of the stack is always driven on the data output, with a valid flag. If the serial side reads past the stored results, the flag is low and the data is zero, which marks the value as undefined. A parameter chooses what happens when the stack is full and another result arrives. In one setting the new result is dropped. In the other, the oldest result is pushed out and the new one goes on top.

Top module: `conv_result_stack`

## Requirements
- R1: After reset, `conv_req_o` is 0, `count_o` is 0, `data_valid_o` is 0 and `data_o` is 0.
- R2: A `conv_start_i` pulse, with no stop-type event in the same cycle, raises `conv_req_o` on the next clock edge. `conv_req_o` then stays high until a stop-type event.
- R3: Each `conv_done_i` pulse while `conv_req_o` is high pushes `conv_data_i` and increments `count_o`. `count_o` never exceeds DEPTH (4).
- R4: Pops return the most recent remaining result first. `data_o` shows the top entry and `data_valid_o` is 1 whenever `count_o` is non-zero. Each `pop_i` pulse, while converting is off and the stack is not empty, decrements `count_o` by one.
- R5: A `rd_addr_i` pulse drops `conv_req_o` on the next edge. Later `conv_done_i` pulses are ignored and leave `count_o` and `data_o` unchanged.
- R6: A `stop_i` pulse drops `conv_req_o` on the next edge.
- R7: A `nack_end_i` pulse drops `conv_req_o` on the next edge.
- R8: A `flush_i` pulse empties the stack (`count_o` = 0, `data_valid_o` = 0) and drops `conv_req_o` on the next edge.
- R9: With OVERWRITE = 0, a result arriving while four are held is dropped. The count stays 4 and the stored results are unchanged.
- R10: With OVERWRITE = 1, a result arriving while four are held discards the oldest entry. The new result becomes the top and the count stays 4.
- R11: A pop on an empty stack has no effect: `count_o` stays 0, `data_valid_o` is 0 and `data_o` is 0.
- R12: `pop_i` is ignored while `conv_req_o` is high.
- R13: `conv_start_i` empties the stack before new results are collected. A stop-type event in the same cycle as `conv_start_i` takes priority, so `conv_req_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start_i | input | 1 | Valid command received: begin converting |
| stop_i | input | 1 | Bus STOP seen |
| nack_end_i | input | 1 | Not-acknowledge issued after a repeated command |
| rd_addr_i | input | 1 | Read address received |
| flush_i | input | 1 | Malformed command: empty the stack |
| pop_i | input | 1 | One word read out |
| conv_done_i | input | 1 | Converter finished a result |
| conv_data_i | input | DATA_W | Result from the converter |
| conv_req_o | output | 1 | Converter enable / conversion request |
| data_o | output | DATA_W | Top-of-stack result, 0 when empty |
| data_valid_o | output | 1 | data_o holds a stored result |
| count_o | output | $clog2(DEPTH+1) | Number of stored results |

## Verification
Two instances, one with each full-stack policy, get the same five distinct results in a row. The fifth result separates dropping from overwriting by the pop order that follows. Short runs cut off by each of the four stop-type events show that every one of them puts the converter to sleep and that later done pulses are ignored. Pops while converting and pops past the bottom of the stack show that both are ignored. A start in the same cycle as a stop shows which of the two wins.

// File: rtl/conv_result_stack.sv
module conv_result_stack #(
  parameter int DATA_W    = 12,
  parameter int DEPTH     = 4,
  parameter bit OVERWRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start_i,
  input  logic              stop_i,
  input  logic              nack_end_i,
  input  logic              rd_addr_i,
  input  logic              flush_i,
  input  logic              pop_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              conv_req_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CW-1:0]     cnt;
  logic              en;

  wire halt   = stop_i | nack_end_i | rd_addr_i | flush_i;
  wire clear  = flush_i | conv_start_i;
  wire full   = (cnt == CW'(DEPTH));
  wire push   = en & conv_done_i & ~clear & (~full | OVERWRITE);
  wire pop    = pop_i & ~en & ~clear & (cnt != '0);
  wire [AW-1:0] top = AW'(cnt - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            en <= 1'b0;
    else if (halt)         en <= 1'b0;
    else if (conv_start_i) en <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (push && !full)    cnt <= cnt + CW'(1);
    else if (pop)              cnt <= cnt - CW'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= '0;
      else if (push) begin
        if (full) begin
          if (i == DEPTH-1) mem[i] <= conv_data_i;
          else              mem[i] <= mem[(i+1) % DEPTH];
        end else if (cnt == CW'(i)) begin
          mem[i] <= conv_data_i;
        end
      end
    end
  end

  assign conv_req_o   = en;
  assign count_o      = cnt;
  assign data_valid_o = (cnt != '0);
  assign data_o       = data_valid_o ? mem[top] : '0;

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start_i && !halt) |=> (conv_req_o && count_o == '0));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH));
  p_pop_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !conv_req_o && count_o != '0 && !flush_i && !conv_start_i)
      |=> (count_o == $past(count_o) - CW'(1)));
  p_rd_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_i |=> !conv_req_o);
  p_stop_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !conv_req_o);
  p_nack_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nack_end_i |=> !conv_req_o);
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (count_o == '0 && !conv_req_o && !data_valid_o));
  p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CW'(DEPTH) && conv_done_i && !flush_i && !conv_start_i)
      |=> (count_o == CW'(DEPTH)));
  p_idle_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_req_o && !pop_i && !flush_i && !conv_start_i) |=> $stable(count_o));
endmodule

// File: tb/conv_result_stack_tb_top.sv
module conv_result_stack_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, stp = 0, nck = 0, rda = 0, fl = 0, pp = 0, dn = 0;
  logic [11:0] din = '0;
  logic        req_a, req_b, val_a, val_b;
  logic [11:0] dat_a, dat_b;
  logic [2:0]  cnt_a, cnt_b;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  conv_result_stack #(.DATA_W(12), .DEPTH(4), .OVERWRITE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_start_i(start), .stop_i(stp),
    .nack_end_i(nck), .rd_addr_i(rda), .flush_i(fl), .pop_i(pp),
    .conv_done_i(dn), .conv_data_i(din), .conv_req_o(req_a),
    .data_o(dat_a), .data_valid_o(val_a), .count_o(cnt_a));

  conv_result_stack #(.DATA_W(12), .DEPTH(4), .OVERWRITE(1'b1)) dut_ow_i (
    .clk(clk), .rst_n(rst_n), .conv_start_i(start), .stop_i(stp),
    .nack_end_i(nck), .rd_addr_i(rda), .flush_i(fl), .pop_i(pp),
    .conv_done_i(dn), .conv_data_i(din), .conv_req_o(req_b),
    .data_o(dat_b), .data_valid_o(val_b), .count_o(cnt_b));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic clr();
    start = 0; stp = 0; nck = 0; rda = 0; fl = 0; pp = 0; dn = 0;
  endtask
  task automatic p_start(); start = 1; cyc(); clr(); endtask
  task automatic p_done(logic [11:0] v); dn = 1; din = v; cyc(); clr(); endtask
  task automatic p_pop(); pp = 1; cyc(); clr(); endtask

  task automatic t_reset();
    chk("R1 req", req_a, 0); chk("R1 count", cnt_a, 0);
    chk("R1 valid", val_a, 0); chk("R1 data", dat_a, 0);
  endtask

  task automatic t_fill_and_read();
    p_start();
    chk("R2 req", req_a, 1); chk("R13 empty at start", cnt_a, 0);
    p_done(12'h1A1); p_done(12'h2B2); p_done(12'h3C3);
    chk("R3 count3", cnt_a, 3); chk("R2 req held", req_a, 1);
    p_done(12'h4D4);
    chk("R3 count4", cnt_a, 4); chk("R4 top", dat_a, 12'h4D4);
    p_done(12'h5E5);
    chk("R9 count", cnt_a, 4); chk("R9 top", dat_a, 12'h4D4);
    chk("R10 count", cnt_b, 4); chk("R10 top", dat_b, 12'h5E5);
    rda = 1; cyc(); clr();
    chk("R5 req off", req_a, 0);
    p_done(12'h777);
    chk("R5 ignored count", cnt_a, 4); chk("R5 ignored data", dat_a, 12'h4D4);
    chk("R4 valid", val_a, 1);
    p_pop(); chk("R4 pop2", dat_a, 12'h3C3); chk("R10 pop2", dat_b, 12'h4D4);
    chk("R4 count", cnt_a, 3);
    p_pop(); chk("R4 pop3", dat_a, 12'h2B2); chk("R10 pop3", dat_b, 12'h3C3);
    p_pop(); chk("R4 pop4", dat_a, 12'h1A1); chk("R10 pop4", dat_b, 12'h2B2);
    p_pop(); chk("R9 empty", cnt_a, 0); chk("R4 invalid", val_a, 0);
    p_pop();
    chk("R11 count", cnt_a, 0); chk("R11 valid", val_a, 0); chk("R11 data", dat_a, 0);
  endtask

  task automatic t_stop();
    p_start(); p_done(12'h0F0);
    pp = 1; cyc(); clr();
    chk("R12 pop ignored", cnt_a, 1); chk("R12 data", dat_a, 12'h0F0);
    stp = 1; cyc(); clr();
    chk("R6 req off", req_a, 0);
    p_done(12'h111);
    chk("R6 done ignored", cnt_a, 1); chk("R6 data kept", dat_a, 12'h0F0);
  endtask

  task automatic t_nack();
    p_start();
    chk("R13 cleared", cnt_a, 0);
    p_done(12'h222);
    nck = 1; cyc(); clr();
    chk("R7 req off", req_a, 0); chk("R7 count", cnt_a, 1);
  endtask

  task automatic t_flush();
    p_start(); p_done(12'h333); p_done(12'h444);
    fl = 1; cyc(); clr();
    chk("R8 count", cnt_a, 0); chk("R8 valid", val_a, 0); chk("R8 req", req_a, 0);
  endtask

  task automatic t_start_vs_stop();
    start = 1; stp = 1; cyc(); clr();
    chk("R13 stop wins", req_a, 0);
    p_done(12'h555);
    chk("R13 no push", cnt_a, 0);
  endtask

  initial begin
    clr();
    repeat (3) cyc();
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_fill_and_read();
    t_stop();
    t_nack();
    t_flush();
    t_start_vs_stop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule